// File: doc/BRIEF.md
# Bit-Plane Colour Dot Generator

This block turns three separately stored bit planes (red, green and blue, each 16 KB) into a stream of 3-bit colour dots for a raster display. A display controller supplies the per-line start address, the scan-row number and the number of six-dot character cells on the line. The block then forms the byte address of the line. It reads one byte from every plane for each 16 dots through synchronous read ports with one cycle of latency, and sends the bits out most significant first, one dot per clock.

Two rendering modes exist. In colour mode every stored bit is shown for two dots, so each plane gives a half-rate bit. In dense mode the red channel is dark and blue stays half rate. Green runs at full rate: the first eight dots of each 16-dot group come from the green byte and the last eight from the red byte. The mode is latched when a line starts. Between lines the colour output is black and no reads are issued.

Top module: `planar_dot_gen`

## Requirements
- R1: While reset is applied and after it is released, with no line started, `pix_valid`, `pix_rgb` and `plane_rd_en` are all 0.
- R2: A start accepted at clock edge E0 puts `plane_rd_en` high in the cycle after E0. In that cycle `plane_rd_addr` = ((`line_ma` << 1) | (`line_ra` << 6)) + 2, taken modulo 2^14.
- R3: A line of C cells has N = 6·C dots. Dot x (0 ≤ x < N) is shown with `pix_valid` = 1 in the cycle after edge E0+2+x, so the dots follow each other with no gap. `pix_valid` is 0 after the last dot.
- R4: Byte j of the line is read once, at address (base + j) mod 2^14, in the cycle after edge E0+16·j. Bytes are read for j = 0 … ⌊(N−1)/16⌋ only. Dot x uses byte ⌊x/16⌋.
- R5: In colour mode (`dd_sel` = 0 at the start), `pix_rgb` = {B[k], G[k], R[k]} with k = 7 − ⌊x/2⌋ mod 8. Bit 0 is red, bit 1 green and bit 2 blue, so codes 0 to 7 mean black, red, green, yellow, blue, magenta, cyan and white.
- R6: In dense mode (`dd_sel` = 1 at the start), bit 0 is 0 and bit 2 is B[7 − ⌊x/2⌋ mod 8]. Bit 1 is taken from bit 7 − (x mod 8) of the red byte when bit 3 of x is 1, and of the green byte when it is 0.
- R7: `dd_sel`, `line_ma`, `line_ra` and `line_chars` are sampled only in the cycle a start is accepted. Changing them during a line does not change its dots or its reads.
- R8: Outside a line `pix_rgb` is 0 and `plane_rd_en` is 0. No more than one read is issued in any two consecutive cycles.
- R9: A `line_go` pulse while a line is in progress is ignored and does not change the current line's reads or dots.
- R10: A `line_go` with `line_chars` = 0 starts nothing: no read and no dot follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_go | input | 1 | Start-of-line pulse |
| line_ma | input | 14 | Controller memory address for the line |
| line_ra | input | 5 | Controller scan-row address |
| line_chars | input | 8 | Character cells on the line (6 dots each) |
| dd_sel | input | 1 | Dense mode select, sampled at line start |
| plane_rd_en | output | 1 | Read strobe to all three plane memories |
| plane_rd_addr | output | 14 | Plane byte address |
| plane_r_data | input | 8 | Red plane byte, valid one cycle after the read |
| plane_g_data | input | 8 | Green plane byte, valid one cycle after the read |
| plane_b_data | input | 8 | Blue plane byte, valid one cycle after the read |
| pix_valid | output | 1 | Dot strobe |
| pix_rgb | output | 3 | Colour index {blue, green, red} |

## Verification
Each result has a fixed cycle offset from the edge E0 that accepts a start. Byte read j is due in the cycle after E0+16·j, and dot x in the cycle after E0+2+x. The bench driver records E0 from a free-running cycle counter and queues every expected read and dot together with its due cycle. The monitor samples on the falling edge and compares both the value and the cycle number. An item that is late, early or missing, or any read or dot that appears with nothing queued, is reported against its requirement.

// File: rtl/bpx_pkg.sv
package bpx_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PRIME = 2'd1,
    SQ_RUN   = 2'd2
  } seq_st_t;

  localparam int unsigned NPLANE   = 3;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LANE_W   = 4;   // log2 of dots per fetched byte (16)
  localparam int unsigned PL_RED   = 0;
  localparam int unsigned PL_GREEN = 1;
  localparam int unsigned PL_BLUE  = 2;

  typedef logic [NPLANE-1:0][BYTE_W-1:0] plane_set_t;

endpackage

// File: rtl/bpx_seq.sv
module bpx_seq
  import bpx_pkg::*;
#(
  parameter int AW     = 14,
  parameter int MAW    = 14,
  parameter int RAW    = 5,
  parameter int CW     = 8,
  parameter int CELL_W = 6,
  parameter int XW     = CW + $clog2(CELL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [MAW-1:0]    ma,
  input  logic [RAW-1:0]    ra,
  input  logic [CW-1:0]     chars,
  input  logic              dd_in,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic              dot_act,
  output logic [LANE_W-1:0] dot_lane,
  output logic              load_byte,
  output logic              dd_line
);

  localparam int WW = MAW + RAW + 7;

  seq_st_t        st_q, st_d;
  logic [XW-1:0]  x_q, x_d;
  logic [XW-1:0]  last_q, last_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic           dd_q, dd_d;
  logic           cfg_ld;
  logic           fetch;
  logic [WW-1:0]  row_wide;
  logic [AW-1:0]  base_w;
  logic [XW-1:0]  span_w;
  logic           lane_end;
  logic           at_last;

  // line base address from controller fields
  always_comb begin
    row_wide = (WW'(ma) << 1) | (WW'(ra) << 6);
    base_w   = AW'(row_wide) + AW'(2);
    span_w   = XW'(chars) * XW'(CELL_W);
  end

  assign lane_end = (x_q[LANE_W-1:0] == {LANE_W{1'b1}});
  assign at_last  = (x_q == last_q);

  // next-state
  always_comb begin
    st_d   = st_q;
    x_d    = x_q;
    last_d = last_q;
    addr_d = addr_q;
    dd_d   = dd_q;
    cfg_ld = 1'b0;
    fetch  = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (go && (chars != '0)) begin
          cfg_ld = 1'b1;
          st_d   = SQ_PRIME;
          last_d = span_w - XW'(1);
          addr_d = base_w;
          dd_d   = dd_in;
          x_d    = '0;
        end
      end
      SQ_PRIME: begin
        fetch = 1'b1;
        st_d  = SQ_RUN;
        x_d   = '0;
      end
      SQ_RUN: begin
        if (lane_end && !at_last) fetch = 1'b1;
        if (at_last) st_d = SQ_IDLE;
        else         x_d  = x_q + XW'(1);
      end
      default: st_d = SQ_IDLE;
    endcase
    if (fetch) addr_d = addr_q + AW'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      x_q    <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      x_q    <= x_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      dd_q   <= 1'b0;
    end else if (cfg_ld) begin
      last_q <= last_d;
      dd_q   <= dd_d;
    end
  end

  assign rd_en     = fetch;
  assign rd_addr   = addr_q;
  assign dot_act   = (st_q == SQ_RUN);
  assign dot_lane  = x_q[LANE_W-1:0];
  assign load_byte = dot_act && (x_q[LANE_W-1:0] == '0);
  assign dd_line   = dd_q;

  // R3: dot counter never passes the line length
  assert_x_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RUN) |-> (x_q <= last_q));

  // R7: mode stays fixed for the whole line
  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SQ_RUN) && ($past(st_q) == SQ_RUN)) |-> $stable(dd_q));

  // R9: a start during a line leaves the line length untouched
  assert_busy_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SQ_RUN) && go) |=> (last_q == $past(last_q)));

  // R10: empty line request never leaves idle
  assert_empty_go_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SQ_IDLE) && go && (chars == '0)) |=> (st_q == SQ_IDLE));

endmodule

// File: rtl/bpx_hold.sv
module bpx_hold
  import bpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  plane_set_t rdata,
  output plane_set_t cur
);

  plane_set_t hold_q;

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_q[p] <= '0;
      else if (load) hold_q[p] <= rdata[p];
    end
    // the first dot of a byte uses the read port directly
    assign cur[p] = load ? rdata[p] : hold_q[p];
  end

endmodule

// File: rtl/bpx_dot.sv
module bpx_dot
  import bpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic [LANE_W-1:0] lane,
  input  logic              dd,
  input  plane_set_t        cur,
  output logic              vld,
  output logic [2:0]        rgb
);

  logic [2:0] bl, bh;
  logic       r_b, g_b, b_b;
  logic [2:0] rgb_d;
  logic       vld_q, dd_q;
  logic [2:0] rgb_q;

  always_comb begin
    bl  = 3'd7 - lane[3:1];
    bh  = 3'd7 - lane[2:0];
    b_b = cur[PL_BLUE][bl];
    if (dd) begin
      r_b = 1'b0;
      g_b = lane[3] ? cur[PL_RED][bh] : cur[PL_GREEN][bh];
    end else begin
      r_b = cur[PL_RED][bl];
      g_b = cur[PL_GREEN][bl];
    end
    rgb_d = act ? {b_b, g_b, r_b} : 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rgb_q <= '0;
      dd_q  <= 1'b0;
    end else begin
      vld_q <= act;
      rgb_q <= rgb_d;
      dd_q  <= dd;
    end
  end

  assign vld = vld_q;
  assign rgb = rgb_q;

  // R6: red channel dark on dense lines
  assert_dense_red_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && dd_q) |-> (rgb_q[0] == 1'b0));

endmodule

// File: rtl/planar_dot_gen.sv
module planar_dot_gen
  import bpx_pkg::*;
#(
  parameter int AW     = 14,
  parameter int MAW    = 14,
  parameter int RAW    = 5,
  parameter int CW     = 8,
  parameter int CELL_W = 6
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            line_go,
  input  logic [MAW-1:0]  line_ma,
  input  logic [RAW-1:0]  line_ra,
  input  logic [CW-1:0]   line_chars,
  input  logic            dd_sel,
  output logic            plane_rd_en,
  output logic [AW-1:0]   plane_rd_addr,
  input  logic [7:0]      plane_r_data,
  input  logic [7:0]      plane_g_data,
  input  logic [7:0]      plane_b_data,
  output logic            pix_valid,
  output logic [2:0]      pix_rgb
);

  localparam int XW = CW + $clog2(CELL_W);

  logic [1:0]        rs_q;
  logic              rst_n;
  logic              dot_act;
  logic [LANE_W-1:0] dot_lane;
  logic              load_byte;
  logic              dd_line;
  plane_set_t        rdata;
  plane_set_t        cur;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  always_comb begin
    rdata[PL_RED]   = plane_r_data;
    rdata[PL_GREEN] = plane_g_data;
    rdata[PL_BLUE]  = plane_b_data;
  end

  bpx_seq #(
    .AW(AW), .MAW(MAW), .RAW(RAW), .CW(CW), .CELL_W(CELL_W), .XW(XW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (line_go),
    .ma        (line_ma),
    .ra        (line_ra),
    .chars     (line_chars),
    .dd_in     (dd_sel),
    .rd_en     (plane_rd_en),
    .rd_addr   (plane_rd_addr),
    .dot_act   (dot_act),
    .dot_lane  (dot_lane),
    .load_byte (load_byte),
    .dd_line   (dd_line)
  );

  bpx_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_byte),
    .rdata (rdata),
    .cur   (cur)
  );

  bpx_dot u_dot (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (dot_act),
    .lane  (dot_lane),
    .dd    (dd_line),
    .cur   (cur),
    .vld   (pix_valid),
    .rgb   (pix_rgb)
  );

  // R8: black whenever no dot is shown
  assert_black_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (pix_rgb == 3'd0));

  // R8: reads never in consecutive cycles
  assert_read_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    plane_rd_en |=> !plane_rd_en);

  // R4: a read in a line is followed by a dot stream
  assert_read_then_dot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_rd_en && !dot_act) |=> dot_act);

endmodule

// File: tb/tb_planar_dot_gen.sv
module tb_planar_dot_gen;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        line_go;
  logic [13:0] line_ma;
  logic [4:0]  line_ra;
  logic [7:0]  line_chars;
  logic        dd_sel;
  logic        plane_rd_en;
  logic [13:0] plane_rd_addr;
  logic [7:0]  plane_r_data, plane_g_data, plane_b_data;
  logic        pix_valid;
  logic [2:0]  pix_rgb;

  always #5 clk = ~clk;

  planar_dot_gen dut (
    .clk(clk), .rst_ni(rst_ni), .line_go(line_go), .line_ma(line_ma),
    .line_ra(line_ra), .line_chars(line_chars), .dd_sel(dd_sel),
    .plane_rd_en(plane_rd_en), .plane_rd_addr(plane_rd_addr),
    .plane_r_data(plane_r_data), .plane_g_data(plane_g_data),
    .plane_b_data(plane_b_data), .pix_valid(pix_valid), .pix_rgb(pix_rgb)
  );

  // plane contents are a computed pattern
  function automatic logic [7:0] pmem(input int p, input logic [13:0] a);
    logic [7:0] v;
    v = 8'(a[7:0] * 8'd29) ^ {a[13:8], a[1:0]} ^ 8'(p * 91 + 51);
    return v;
  endfunction

  always @(posedge clk) begin
    if (plane_rd_en) begin
      plane_r_data <= pmem(0, plane_rd_addr);
      plane_g_data <= pmem(1, plane_rd_addr);
      plane_b_data <= pmem(2, plane_rd_addr);
    end
  end

  function automatic logic [2:0] exp_dot(input logic [13:0] a, input int x, input bit dd);
    logic [7:0] rb, gb, bb;
    int bl, bh;
    rb = pmem(0, a); gb = pmem(1, a); bb = pmem(2, a);
    bl = 7 - ((x / 2) % 8);
    bh = 7 - (x % 8);
    if (dd) return {bb[bl], ((x & 8) != 0) ? rb[bh] : gb[bh], 1'b0};
    return {bb[bl], gb[bl], rb[bl]};
  endfunction

  typedef struct { logic [13:0] addr; int cyc; } fexp_t;
  typedef struct { logic [2:0] rgb; int cyc; bit dd; } dexp_t;

  fexp_t fq[$];
  dexp_t dq[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int stray = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares reads and dots against the queues
  always @(negedge clk) begin
    if (mon_on) begin
      while (fq.size() > 0 && fq[0].cyc < cyc) begin
        checks++; fails++;
        $display("FAIL R4 missing read: actual none, expected addr %h at cycle %0d", fq[0].addr, fq[0].cyc);
        void'(fq.pop_front());
      end
      while (dq.size() > 0 && dq[0].cyc < cyc) begin
        checks++; fails++;
        $display("FAIL R3 missing dot: actual none, expected rgb %0d at cycle %0d", dq[0].rgb, dq[0].cyc);
        void'(dq.pop_front());
      end
      if (plane_rd_en) begin
        checks++;
        if (fq.size() == 0) begin
          fails++; stray++;
          $display("FAIL R8 stray read: actual addr %h, expected no read", plane_rd_addr);
        end else begin
          fexp_t f;
          f = fq.pop_front();
          if (f.addr != plane_rd_addr || f.cyc != cyc) begin
            fails++;
            $display("FAIL R2/R4 read: actual addr %h cycle %0d, expected addr %h cycle %0d",
                     plane_rd_addr, cyc, f.addr, f.cyc);
          end
        end
      end
      if (pix_valid) begin
        checks++;
        if (dq.size() == 0) begin
          fails++; stray++;
          $display("FAIL R3 stray dot: actual rgb %0d, expected none", pix_rgb);
        end else begin
          dexp_t d;
          d = dq.pop_front();
          if (d.rgb != pix_rgb || d.cyc != cyc) begin
            fails++;
            $display("FAIL %s dot: actual rgb %0d cycle %0d, expected rgb %0d cycle %0d",
                     d.dd ? "R6" : "R5", pix_rgb, cyc, d.rgb, d.cyc);
          end
        end
      end else if (pix_rgb != 3'd0) begin
        checks++; fails++;
        $display("FAIL R8 idle colour: actual %0d, expected 0", pix_rgb);
      end
    end
  end

  // driver: starts a line and queues what it must produce
  task automatic run_line(input logic [13:0] ma, input logic [4:0] ra,
                          input int chars, input bit dd, input bit busy_go);
    int c0, n, nb;
    logic [13:0] base;
    @(negedge clk);
    c0 = cyc + 1;
    line_go = 1'b1; line_ma = ma; line_ra = ra; line_chars = 8'(chars); dd_sel = dd;
    n = chars * 6;
    base = 14'(({1'b0, ma} << 1) | (15'(ra) << 6)) + 14'd2;
    if (n > 0) begin
      nb = (n - 1) / 16 + 1;
      for (int j = 0; j < nb; j++) fq.push_back('{addr: base + 14'(j), cyc: c0 + 16 * j});
      for (int x = 0; x < n; x++)
        dq.push_back('{rgb: exp_dot(base + 14'(x / 16), x, dd), cyc: c0 + 2 + x, dd: dd});
    end
    @(negedge clk);
    // R7: inputs change after the start was taken
    line_go = 1'b0; line_ma = ~ma; line_ra = ~ra; line_chars = 8'(chars + 3); dd_sel = ~dd;
    if (busy_go) begin
      repeat (6) @(negedge clk);
      // R9: start pulse during the line
      line_go = 1'b1; line_chars = 8'd9; line_ma = 14'h0155;
      @(negedge clk);
      line_go = 1'b0;
    end
    while (cyc < c0 + n + 4) @(negedge clk);
    checks++;
    if (fq.size() != 0 || dq.size() != 0) begin
      fails++;
      $display("FAIL R3 line end: actual %0d reads/%0d dots left, expected 0/0", fq.size(), dq.size());
    end
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int s0;
    rst_ni = 1'b0; line_go = 1'b0; line_ma = '0; line_ra = '0; line_chars = '0; dd_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (pix_valid !== 1'b0 || pix_rgb !== 3'd0 || plane_rd_en !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: actual v=%b rgb=%0d rd=%b, expected 0 0 0", pix_valid, pix_rgb, plane_rd_en);
    end
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    checks++;
    if (pix_valid !== 1'b0 || pix_rgb !== 3'd0 || plane_rd_en !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset: actual v=%b rgb=%0d rd=%b, expected 0 0 0", pix_valid, pix_rgb, plane_rd_en);
    end
    mon_on = 1'b1;

    run_line(14'h0123, 5'd3, 8, 1'b0, 1'b0);   // R5 colour mode, 3 reads
    run_line(14'h0040, 5'd7, 11, 1'b1, 1'b0);  // R6 dense, partial last byte
    run_line(14'h1FFF, 5'd0, 6, 1'b0, 1'b0);   // R2 base wraps to 0
    run_line(14'h0000, 5'd31, 5, 1'b1, 1'b0);  // R2 row field high bits
    run_line(14'h0A5A, 5'd12, 1, 1'b1, 1'b0);  // R4 single read, 6 dots
    run_line(14'h0311, 5'd9, 12, 1'b0, 1'b1);  // R9 start while busy
    run_line(14'h07F0, 5'd21, 40, 1'b1, 1'b1); // R6/R9 long dense line

    // R10: zero-cell start produces nothing
    s0 = stray;
    @(negedge clk);
    line_go = 1'b1; line_chars = 8'd0; line_ma = 14'h0200;
    @(negedge clk);
    line_go = 1'b0;
    repeat (20) @(negedge clk);
    checks++;
    if (stray != s0) begin
      fails++;
      $display("FAIL R10 empty start: actual %0d stray events, expected 0", stray - s0);
    end

    run_line(14'h3FFF, 5'd31, 255, 1'b0, 1'b0); // R3 longest line

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule